// File: doc/BRIEF.md
# Oversampled Manchester Line Decoder

This block turns a single-wire Manchester stream back into plain data bits. A local clock samples the line at a fixed multiple of the bit rate, eight samples per bit by default. The data value of each bit is carried by the line transition in the middle of the bit period. A low-to-high change means 0 and a high-to-low change means 1. A transition between two bit periods carries no data. The decoder keeps no recovered clock. It counts samples from the last accepted data transition. Edges that arrive too soon after that transition are treated as overhead. The first edge after that blanking interval is taken as the next data transition, and the count restarts from it, so the phase follows the sender on every bit.

A receive path feeds the raw line into `line_i` and holds `en_i` high. It collects `bit_o` on every cycle where `bit_valid_o` is high. If the line goes quiet for too long, the decoder reports a coding error and returns to hunting. While hunting, it accepts the first edge it sees as a data transition. A sender therefore starts each stream from a known idle level with a preamble, and the decoder locks onto it.

Top module: `manch_line_decoder`

## Requirements
- R1: After `rst_ni` is released, `bit_o`, `bit_valid_o` and `code_err_o` are 0 and the decoder is hunting. A line held at a constant level produces no strobe and no error.
- R2: An accepted rising transition yields `bit_o` = 0 and an accepted falling transition yields `bit_o` = 1. `bit_valid_o` is high for exactly one cycle per accepted transition, and `bit_o` changes only in such a cycle.
- R3: The strobe and the new `bit_o` appear on the third rising clock edge after the line changes: two synchroniser stages plus one output register.
- R4: Any edge seen 1 to 6 samples (OVS*3/4) after an accepted data transition is ignored. This covers boundary transitions and short glitches, and such an edge produces no strobe and no error.
- R5: An edge seen 7 to 10 samples after an accepted data transition is accepted as data, and the sample count restarts from it. Bit periods of 7, 9 and 10 samples therefore decode without error.
- R6: If no edge is seen within 10 samples (OVS + OVS/4) of an accepted data transition, `code_err_o` is high for one cycle, 10 cycles after that transition's strobe, with no strobe in the same cycle. The decoder then returns to hunting.
- R7: While hunting, the first edge seen is accepted as a data transition, whatever its distance from earlier edges.
- R8: While `en_i` is low, no strobe and no error are produced, `bit_o` holds its value, and the decoder is put back into hunting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, OVS times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw Manchester line, asynchronous to `clk_i` |
| en_i | input | 1 | Decoder enable; low forces hunting |
| bit_o | output | 1 | Last decoded data bit |
| bit_valid_o | output | 1 | One-cycle strobe marking a new `bit_o` |
| code_err_o | output | 1 | One-cycle flag: no data transition within the timeout |

## Verification
A line change the bench drives after rising edge n produces its strobe on edge n+3. The bench logs the cycle of every mid-period change it drives and checks that each strobe lands exactly three cycles later, with the expected bit. A missing data transition makes the error pulse due 10 cycles after the strobe of the last accepted transition, which is 13 cycles after the line change. The bench compares the logged error cycle against that figure. The bench samples on the falling clock edge and waits well past the timeout before each comparison, so every due event has been recorded before the bench compares it.

// File: rtl/manch_pkg.sv
package manch_pkg;
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } trk_state_e;

  typedef struct packed {
    logic seen;
    logic fall;
  } line_edge_t;
endpackage

// File: rtl/manch_sync.sv
module manch_sync #(
  parameter int STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_i,
  output manch_pkg::line_edge_t edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= line_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], line_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign edge_o.seen = chain_q[STAGES-1] ^ prev_q;
  assign edge_o.fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/manch_phase.sv
module manch_phase #(
  parameter int OVS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  manch_pkg::line_edge_t edge_i,
  output logic                  accept_o,
  output logic                  timeout_o
);
  import manch_pkg::*;

  localparam int BLANK = (OVS * 3) / 4;
  localparam int LIMIT = OVS + OVS / 4;
  localparam int CW    = $clog2(LIMIT + 1);

  trk_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hunting;

  assign hunting   = (state_q == ST_HUNT);
  // edges inside the blanking window are boundary overhead
  assign accept_o  = en_i && edge_i.seen && (hunting || (cnt_q > CW'(BLANK)));
  assign timeout_o = en_i && !hunting && (cnt_q == CW'(LIMIT)) && !accept_o;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_i || timeout_o) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
    end else if (accept_o) begin
      state_d = ST_TRACK;
      cnt_d   = CW'(1);
    end else if (!hunting) begin
      cnt_d   = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
endmodule

// File: rtl/manch_out.sv
module manch_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic fall_i,
  input  logic timeout_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic code_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      code_err_o  <= 1'b0;
    end else begin
      bit_valid_o <= accept_i;
      code_err_o  <= timeout_i;
      if (accept_i) bit_o <= fall_i;
    end
endmodule

// File: rtl/manch_line_decoder.sv
module manch_line_decoder #(
  parameter int OVS         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic en_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic code_err_o
);
  manch_pkg::line_edge_t line_edge;
  logic accept, timeout;

  manch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .edge_o (line_edge)
  );

  manch_phase #(.OVS(OVS)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .edge_i    (line_edge),
    .accept_o  (accept),
    .timeout_o (timeout)
  );

  manch_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .fall_i      (line_edge.fall),
    .timeout_i   (timeout),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o),
    .code_err_o  (code_err_o)
  );
endmodule

// File: rtl/manch_line_decoder_chk.sv
module manch_line_decoder_chk #(
  parameter int OVS = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic en_i,
  input logic bit_o,
  input logic bit_valid_o,
  input logic code_err_o
);
  localparam int BLANK = (OVS * 3) / 4;
  localparam int LIMIT = OVS + OVS / 4;

  logic [7:0] since_q;
  logic       open_q;
  logic [2:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      since_q <= '0;
      open_q  <= 1'b1;
      age_q   <= '0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      if (bit_valid_o)           since_q <= 8'd1;
      else if (since_q != 8'hff) since_q <= since_q + 8'd1;
      if (!en_i || code_err_o) open_q <= 1'b1;
      else if (bit_valid_o)    open_q <= 1'b0;
    end

  p_strobe_err_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid_o && code_err_o));

  p_bit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> $stable(bit_o));

  p_blank_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (open_q || since_q > 8'(BLANK)));

  p_timeout_at_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o |-> (!open_q && since_q == 8'(LIMIT)));

  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bit_valid_o && !code_err_o));

  p_latency_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && age_q >= 3'd5) |->
      ($past(line_i, 3) != $past(line_i, 4) && bit_o == $past(line_i, 4)));
endmodule

bind manch_line_decoder manch_line_decoder_chk #(.OVS(OVS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_i      (line_i),
  .en_i        (en_i),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o),
  .code_err_o  (code_err_o)
);

// File: tb/manch_line_decoder_tb_top.sv
module manch_line_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int TMO        = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic en = 1'b0;
  logic bit_out, bit_vld, code_err;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  bit got_bits[$];
  int got_cyc[$];
  int err_cyc[$];
  bit exp_bits[$];
  int exp_cyc[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  manch_line_decoder dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_i      (line),
    .en_i        (en),
    .bit_o       (bit_out),
    .bit_valid_o (bit_vld),
    .code_err_o  (code_err)
  );

  always @(negedge clk) if (rst_n) begin
    if (bit_vld) begin
      got_bits.push_back(bit_out);
      got_cyc.push_back(cyc);
    end
    if (code_err) err_cyc.push_back(cyc);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    got_bits.delete(); got_cyc.delete(); err_cyc.delete();
    exp_bits.delete(); exp_cyc.delete();
  endtask

  // first half at level b, mid change logged, second half at ~b
  task automatic send_bit(bit b, int first_len, int second_len);
    line = b;
    repeat (first_len) @(negedge clk);
    exp_bits.push_back(b);
    exp_cyc.push_back(cyc);
    line = ~b;
    repeat (second_len) @(negedge clk);
  endtask

  task automatic cmp_bits(string req);
    chk(got_bits.size() == exp_bits.size(), {req, " strobe count"}, got_bits.size(), exp_bits.size());
    for (int i = 0; i < got_bits.size() && i < exp_bits.size(); i++) begin
      chk(got_bits[i] == exp_bits[i], {req, " bit value"}, got_bits[i], exp_bits[i]);
      chk(got_cyc[i] == exp_cyc[i] + LAT, "R3 strobe cycle", got_cyc[i], exp_cyc[i] + LAT);
    end
  endtask

  task automatic cmp_end_err(string req);
    int last;
    last = exp_cyc.size() > 0 ? exp_cyc[exp_cyc.size()-1] : 0;
    chk(err_cyc.size() >= 1, {req, " error pulse count"}, err_cyc.size(), 1);
    if (err_cyc.size() >= 1)
      chk(err_cyc[err_cyc.size()-1] == last + LAT + TMO, {req, " error cycle"},
          err_cyc[err_cyc.size()-1], last + LAT + TMO);
  endtask

  task automatic t_reset();
    chk(bit_out == 1'b0, "R1 bit after reset", bit_out, 0);
    chk(bit_vld == 1'b0, "R1 strobe after reset", bit_vld, 0);
    chk(code_err == 1'b0, "R1 error after reset", code_err, 0);
    clear_logs();
    repeat (20) @(negedge clk);
    chk(got_bits.size() == 0, "R1 idle strobes", got_bits.size(), 0);
    chk(err_cyc.size() == 0, "R1 idle errors", err_cyc.size(), 0);
  endtask

  task automatic t_basic();
    bit pat[6] = '{0, 1, 1, 0, 0, 1};
    clear_logs();
    foreach (pat[i]) send_bit(pat[i], 4, 4);
    repeat (20) @(negedge clk);
    cmp_bits("R2");
    chk(got_bits.size() == 6, "R4 boundary edges dropped", got_bits.size(), 6);
    chk(err_cyc.size() == 1, "R6 single error after stream", err_cyc.size(), 1);
    cmp_end_err("R6");
  endtask

  task automatic t_glitch();
    clear_logs();
    send_bit(1'b0, 4, 0);
    // glitch edges land 5 and 6 samples after the data change
    line = 1'b1; repeat (5) @(negedge clk);
    line = 1'b0; repeat (1) @(negedge clk);
    line = 1'b1; repeat (2) @(negedge clk);
    exp_bits.push_back(1'b1);
    exp_cyc.push_back(cyc);
    line = 1'b0; repeat (24) @(negedge clk);
    cmp_bits("R4");
    chk(err_cyc.size() == 1, "R4 glitch raises no extra error", err_cyc.size(), 1);
  endtask

  task automatic t_rates();
    bit pa[4] = '{0, 1, 0, 1};
    bit pb[4] = '{0, 0, 1, 1};
    clear_logs();
    foreach (pa[i]) send_bit(pa[i], 3, 4);
    repeat (20) @(negedge clk);
    cmp_bits("R5 period 7");
    chk(err_cyc.size() == 1, "R5 period 7 errors", err_cyc.size(), 1);
    clear_logs();
    foreach (pb[i]) send_bit(pb[i], 4, 5);
    repeat (20) @(negedge clk);
    cmp_bits("R5 period 9");
    chk(err_cyc.size() == 1, "R5 period 9 errors", err_cyc.size(), 1);
    clear_logs();
    foreach (pa[i]) send_bit(pa[i], 5, 5);
    repeat (20) @(negedge clk);
    cmp_bits("R5 period 10");
    chk(err_cyc.size() == 1, "R5 period 10 errors", err_cyc.size(), 1);
    cmp_end_err("R5");
  endtask

  task automatic t_late();
    int first;
    clear_logs();
    send_bit(1'b0, 4, 4);
    first = exp_cyc[0];
    send_bit(1'b1, 7, 4);
    repeat (20) @(negedge clk);
    cmp_bits("R7");
    chk(err_cyc.size() == 2, "R6 late edge error count", err_cyc.size(), 2);
    if (err_cyc.size() >= 1)
      chk(err_cyc[0] == first + LAT + TMO, "R6 timeout cycle", err_cyc[0], first + LAT + TMO);
  endtask

  task automatic t_disable();
    clear_logs();
    en = 1'b0;
    repeat (2) @(negedge clk);
    send_bit(1'b0, 4, 4);
    send_bit(1'b1, 4, 4);
    send_bit(1'b1, 4, 4);
    repeat (20) @(negedge clk);
    chk(got_bits.size() == 0, "R8 strobes while disabled", got_bits.size(), 0);
    chk(err_cyc.size() == 0, "R8 errors while disabled", err_cyc.size(), 0);
    chk(bit_out == 1'b1, "R8 bit held while disabled", bit_out, 1);
    en = 1'b1;
    repeat (3) @(negedge clk);
    clear_logs();
    send_bit(1'b0, 4, 4);
    send_bit(1'b1, 4, 4);
    repeat (20) @(negedge clk);
    cmp_bits("R8 after enable");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_rates();
    t_late();
    t_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule